// File: doc/BRIEF.md
# Byte Table Lookup Unit

The block assembles a 32-bit word from four independent 8-bit index lanes. Each lane names one byte inside a small table made of 64-bit entries; the byte found there is returned in the same lane of the result. A lane whose index is not below a caller-supplied byte limit does not read the table. It takes the matching byte of a caller-supplied default word instead, so a caller can merge table bytes into an existing word or force chosen lanes to fixed values.

Table entries are loaded through a synchronous write port, one 64-bit entry per cycle. A lookup is requested with a one-cycle start strobe. The result is registered and signalled by a one-cycle done pulse. The result then stays unchanged until the next lookup.

Top module: `byte_lookup_unit`

## Requirements
- R1: After reset `done` is 0, `result` is 0 and every table entry holds zero. A lookup made before any write therefore returns 0 in every in-range lane.
- R2: Lane k of the index word is bits 8k+7..8k, for k = 0 to 3. The byte chosen for lane k is returned in bits 8k+7..8k of `result`, and each lane is independent of the others.
- R3: A lane index is in range only when it is strictly less than the effective limit. The effective limit is `tbl_limit` when that value is 32 or less, and 32 for any larger value.
- R4: For an in-range index i, the entry read is i / 8 (index bits 4..3). The byte read is i mod 8 (index bits 2..0), where byte 0 is bits 7..0 of the entry.
- R5: An out-of-range lane returns bits 8k+7..8k of `dflt_word`, and this does not depend on what the other lanes do.
- R6: When `wr_en` is high at a rising edge, entry `wr_addr` takes the value of `wr_data`. A lookup started at the same edge still sees the old contents, and later lookups see the new contents.
- R7: `done` is high for exactly the one cycle after each edge at which `start` was high. `result` is updated at that same edge.
- R8: While `start` is low, `result` keeps its value whatever the index, default and limit inputs do.
- R9: With a limit of 0 every lane is out of range, so the whole result equals the default word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table entry write strobe |
| wr_addr | input | 2 | Entry number written |
| wr_data | input | 64 | Entry value written |
| start | input | 1 | Lookup request strobe |
| idx_word | input | 32 | Four byte-wide lane indices |
| dflt_word | input | 32 | Per-lane fallback bytes |
| tbl_limit | input | 6 | Byte count that bounds valid indices |
| result | output | 32 | Registered lookup result |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The table is filled with distinct byte values, so a wrong entry or byte selection is visible at once. Identity and reversed index patterns show whether lanes are placed in the right positions. Indices at 31, 32 and above 32, combined with limits of 0, 32 and 63, separate an off-by-one in the range test from a missing clamp. Mixed in-range and out-of-range lanes against a patterned default word show whether lanes fall back independently. A write issued at the same edge as a lookup, and random streams of writes and lookups, show when written data becomes visible.

// File: rtl/btl_pkg.sv
package btl_pkg;
  localparam int LANE_W      = 8;
  localparam int BYTES_PER_E = 8;
  localparam int ENTRY_W     = LANE_W * BYTES_PER_E;
  localparam int DEF_ENTRIES = 4;
  localparam int DEF_LANES   = 4;

  // Clamp the requested byte limit to the table capacity.
  function automatic logic [31:0] clamp_limit(input logic [31:0] req,
                                              input logic [31:0] cap);
    return (req > cap) ? cap : req;
  endfunction

  // True when a lane index falls inside the (already clamped) limit.
  function automatic logic idx_in_range(input logic [LANE_W-1:0] idx,
                                        input logic [31:0] lim);
    return {24'b0, idx} < lim;
  endfunction
endpackage

// File: rtl/btl_table.sv
module btl_table #(
  parameter int N_ENTRIES = btl_pkg::DEF_ENTRIES,
  localparam int EW    = btl_pkg::ENTRY_W,
  localparam int SEL_W = $clog2(N_ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_addr,
  input  logic [EW-1:0]           wr_data,
  output logic [N_ENTRIES*EW-1:0] tbl_flat
);
  logic [EW-1:0] ent_q [N_ENTRIES];

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[e] <= '0;
      end else if (wr_en && (wr_addr == SEL_W'(e))) begin
        ent_q[e] <= wr_data;
      end
    end
    assign tbl_flat[e*EW +: EW] = ent_q[e];
  end

  // R6: a written entry holds the written data one edge later
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tbl_flat[$past(wr_addr)*EW +: EW] == $past(wr_data)));
endmodule

// File: rtl/btl_lane.sv
module btl_lane #(
  parameter int N_ENTRIES = btl_pkg::DEF_ENTRIES,
  localparam int LW    = btl_pkg::LANE_W,
  localparam int EW    = btl_pkg::ENTRY_W,
  localparam int SEL_W = $clog2(N_ENTRIES),
  localparam int POS_W = SEL_W + 3
) (
  input  logic [N_ENTRIES*EW-1:0] tbl_flat,
  input  logic [LW-1:0]           lane_idx,
  input  logic [LW-1:0]           lane_dflt,
  input  logic [31:0]             lim_eff,
  output logic [LW-1:0]           lane_out,
  output logic                    lane_hit
);
  logic [POS_W-1:0] byte_pos;
  logic [LW-1:0]    picked;

  assign lane_hit = btl_pkg::idx_in_range(lane_idx, lim_eff);
  // entry number in the upper bits, byte-in-entry in the low three
  assign byte_pos = lane_idx[POS_W-1:0];
  assign picked   = tbl_flat[{byte_pos, 3'b000} +: LW];
  assign lane_out = lane_hit ? picked : lane_dflt;
endmodule

// File: rtl/byte_lookup_unit.sv
module byte_lookup_unit #(
  parameter int N_ENTRIES = btl_pkg::DEF_ENTRIES,
  parameter int N_LANES   = btl_pkg::DEF_LANES,
  localparam int LW     = btl_pkg::LANE_W,
  localparam int EW     = btl_pkg::ENTRY_W,
  localparam int SEL_W  = $clog2(N_ENTRIES),
  localparam int CAP    = N_ENTRIES * btl_pkg::BYTES_PER_E,
  localparam int LIM_W  = $clog2(CAP + 1),
  localparam int WORD_W = N_LANES * LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_addr,
  input  logic [EW-1:0]     wr_data,
  input  logic              start,
  input  logic [WORD_W-1:0] idx_word,
  input  logic [WORD_W-1:0] dflt_word,
  input  logic [LIM_W-1:0]  tbl_limit,
  output logic [WORD_W-1:0] result,
  output logic              done
);
  logic [N_ENTRIES*EW-1:0] tbl_flat;
  logic [31:0]             lim_eff;
  logic [WORD_W-1:0]       lanes_comb;
  logic [N_LANES-1:0]      lane_hit;
  logic [WORD_W-1:0]       result_q;
  logic                    done_q;

  btl_table #(.N_ENTRIES(N_ENTRIES)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .tbl_flat(tbl_flat)
  );

  assign lim_eff = btl_pkg::clamp_limit(32'(tbl_limit), 32'(CAP));

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    btl_lane #(.N_ENTRIES(N_ENTRIES)) u_lane (
      .tbl_flat (tbl_flat),
      .lane_idx (idx_word[k*LW +: LW]),
      .lane_dflt(dflt_word[k*LW +: LW]),
      .lim_eff  (lim_eff),
      .lane_out (lanes_comb[k*LW +: LW]),
      .lane_hit (lane_hit[k])
    );

    // R5: an out-of-range lane shows the default byte after the edge
    a_r5_lane_default: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !lane_hit[k]) |=>
        (result[k*LW +: LW] == $past(dflt_word[k*LW +: LW])));

    // R3: indices at or past the table capacity never read the table
    a_r3_cap_fallback: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ({24'b0, idx_word[k*LW +: LW]} >= 32'(CAP))) |=>
        (result[k*LW +: LW] == $past(dflt_word[k*LW +: LW])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= start;
      if (start) result_q <= lanes_comb;
    end
  end

  assign result = result_q;
  assign done   = done_q;

  // R7: a request is answered by done on the next cycle
  a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R7: no done without a request
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  // R8: the result is held between requests
  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));
endmodule

// File: tb/byte_lookup_unit_tb_top.sv
module byte_lookup_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        start = 1'b0;
  logic [31:0] idx_word = '0;
  logic [31:0] dflt_word = '0;
  logic [5:0]  tbl_limit = '0;
  logic [31:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_tbl [4];

  always #4 clk = ~clk;

  byte_lookup_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .idx_word(idx_word),
    .dflt_word(dflt_word), .tbl_limit(tbl_limit),
    .result(result), .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model: walk lanes with integer arithmetic
  function automatic logic [31:0] model(input logic [31:0] iw,
                                        input logic [31:0] dw,
                                        input int lim);
    logic [31:0] r = 0;
    int top = (lim > 32) ? 32 : lim;
    for (int k = 0; k < 4; k++) begin
      int v = (iw >> (8 * k)) & 255;
      int b;
      if (v < top) b = int'((m_tbl[v / 8] >> ((v % 8) * 8)) & 64'hff);
      else         b = int'((dw >> (8 * k)) & 32'hff);
      r = r | (32'(b) << (8 * k));
    end
    return r;
  endfunction

  task automatic write_entry(input int a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_tbl[a] = d;
  endtask

  // Lookup, optionally with a write at the same edge
  task automatic lookup(input string req, input logic [31:0] iw,
                        input logic [31:0] dw, input int lim,
                        input logic wr, input int wa, input logic [63:0] wd);
    logic [31:0] exp;
    @(negedge clk);
    idx_word = iw; dflt_word = dw; tbl_limit = 6'(lim); start = 1'b1;
    wr_en = wr; wr_addr = 2'(wa); wr_data = wd;
    exp = model(iw, dw, lim);
    if (wr) m_tbl[wa] = wd;
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0;
    chk({req, " done"}, 64'(done), 64'd1);
    chk({req, " result"}, 64'(result), 64'(exp));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] held;
    void'($urandom(32'd1234));
    for (int e = 0; e < 4; e++) m_tbl[e] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset done", 64'(done), 64'd0);
    chk("R1 reset result", 64'(result), 64'd0);
    rst_n = 1'b1;
    lookup("R1 empty table", 32'h1f_09_03_00, 32'hdead_beef, 32, 0, 0, 0);

    for (int e = 0; e < 4; e++)
      write_entry(e, {8'(8*e+7), 8'(8*e+6), 8'(8*e+5), 8'(8*e+4),
                      8'(8*e+3), 8'(8*e+2), 8'(8*e+1), 8'(8*e)} ^ 64'ha0a0_a0a0_a0a0_a0a0);

    lookup("R2 identity lanes", 32'h03_02_01_00, 32'h0, 32, 0, 0, 0);
    lookup("R2 reversed lanes", 32'h00_01_02_03, 32'h0, 32, 0, 0, 0);
    lookup("R4 entry and byte", 32'h1f_10_08_07, 32'h0, 32, 0, 0, 0);
    lookup("R9 zero limit", 32'h00_01_02_03, 32'h1234_5678, 0, 0, 0, 0);
    lookup("R3 edge at 32", 32'h20_1f_20_1f, 32'hcafe_f00d, 32, 0, 0, 0);
    lookup("R3 edge at limit 5", 32'h06_05_04_00, 32'h5566_7788, 5, 0, 0, 0);
    lookup("R3 clamp above 32", 32'h28_1e_ff_20, 32'h99aa_bbcc, 63, 0, 0, 0);
    lookup("R5 mixed lanes", 32'h80_0c_40_11, 32'h0102_0304, 32, 0, 0, 0);
    lookup("R6 same-edge write old", 32'h0b_0a_09_08, 32'h0, 32, 1, 1,
           64'h1111_2222_3333_4444);
    lookup("R6 write visible later", 32'h0f_0a_09_08, 32'h0, 32, 0, 0, 0);

    held = result;
    @(negedge clk);
    idx_word = 32'h00_00_00_00; dflt_word = 32'hffff_ffff; tbl_limit = 6'd0;
    @(negedge clk);
    chk("R7 done single pulse", 64'(done), 64'd0);
    chk("R8 result held", 64'(result), 64'(held));
    @(negedge clk);
    chk("R8 result still held", 64'(result), 64'(held));

    for (int n = 0; n < 300; n++) begin
      logic [31:0] iw;
      int lim = int'($urandom_range(0, 63));
      iw = $urandom;
      if ($urandom_range(0, 1) == 1) iw = iw & 32'h1f1f_1f1f;
      lookup("R2 R4 R5 random", iw, $urandom, lim,
             1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
             {$urandom, $urandom});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule